// File: doc/BRIEF.md
# Misaligned Data Access Splitter

This block sits between a load/store unit and a 32-bit data memory port. The requester hands over one access at a time: a byte address, a size (byte, halfword or word), a direction and, for stores, right-aligned write data. The block turns that access into the bus transfers the memory can take. On a store it rotates each data byte onto the lane its address selects. On a load it collects the returned lanes and hands back one right-aligned, zero-extended result. Memory is little-endian throughout.

A build parameter selects how a misaligned access is split. In strobe mode the memory honours per-byte write strobes. An access that stays inside one word uses a single word transfer with the matching strobes. An access that crosses a word boundary uses two word transfers. In decomposition mode the memory has no strobes. Every misaligned access is built from naturally aligned byte and halfword transfers, which takes at most three transfers (byte, halfword, byte). A naturally aligned access is always one transfer in either mode.

Top module: `misalign_splitter`

## Requirements
- R1: A naturally aligned access (any byte, a halfword at an even address, a word at an address with bits [1:0] = 0) is issued as exactly one transfer in both modes.
- R2: In strobe mode, a misaligned access that ends inside its starting word is one transfer. Its address has bits [1:0] = 0, and strobe bit i selects byte lane i. A halfword at offset 1 uses strobes 4'b0110.
- R3: In strobe mode, an access that crosses a word boundary is two word-aligned transfers. The first sets strobes from the offset up to lane 3. The second sets strobes from lane 0 for the remaining bytes.
- R4: In decomposition mode, every transfer is naturally aligned. The size field is 0 for byte, 1 for halfword and 2 for word. A misaligned access never uses size 2.
- R5: In decomposition mode, a word at offset 2 becomes two halfwords. A word at offset 1 or 3 becomes a byte, a halfword and a byte. A halfword at an odd address becomes two bytes.
- R6: Pieces are issued in increasing address order. A stalled request keeps its address and piece until it is granted, and the next piece is requested only after that grant.
- R7: A load returns exactly one response pulse. The result holds the byte at the access address in bits [7:0], and higher bytes follow in increasing address order. Bits above the access size read as zero.
- R8: On a store, byte j of the write data (bits [8j+7:8j]) is written to the memory byte at access address + j.
- R9: If any piece returns an error, the response error flag is set. All remaining pieces of that access are still issued and completed.
- R10: The requester ready output is high out of reset and while idle. It is low from the cycle after acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Requester presents an access |
| reqReady | output | 1 | Block can accept an access |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqWdata | input | 32 | Right-aligned store data |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Merged, right-aligned load data |
| rspErr | output | 1 | Any piece reported an error |
| memReq | output | 1 | Transfer request to memory |
| memGnt | input | 1 | Memory accepts the request |
| memWe | output | 1 | Transfer is a write |
| memAddr | output | ADDR_W | Transfer address |
| memSize | output | 2 | Transfer size (decomposition mode) |
| memBe | output | 4 | Byte-lane strobes |
| memWdata | output | 32 | Lane-steered write data |
| memRvalid | input | 1 | Response for the oldest granted transfer |
| memRdata | input | 32 | Response read data |
| memErr | input | 1 | Response error |

## Verification
Two instances, one per mode, receive the same accesses. A table sweeps every size at every byte offset inside one word. This separates single-transfer cases from two-transfer and three-transfer cases, and it checks transfer counts, strobes, alignment, ordering and the merged data against a byte pattern. A store that straddles a word is read back through the block, which exposes wrong lane steering. A stalling memory shows whether a request is held and the piece order kept. An error on only the first piece shows whether the flag is aggregated while the later piece still runs.

// File: rtl/uas_pkg.sv
package uas_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // one bus piece: first access byte it covers and how many bytes
  typedef struct packed {
    logic [1:0] start;
    logic [2:0] len;
  } piece_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       accept;
    logic       issuing;
    logic [1:0] pieceIdx;
    logic       rspBeat;
    logic [1:0] rspIdx;
  } ctrlStrb_t;

  function automatic logic [2:0] sizeBytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic isAligned(input logic [1:0] off, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 1'b1;
      SZ_HALF: return ~off[0];
      default: return (off == 2'd0);
    endcase
  endfunction

  function automatic logic [1:0] pieceCount(input logic strobeMode,
                                            input logic [1:0] off,
                                            input logic [1:0] sz);
    logic [2:0] n;
    n = sizeBytes(sz);
    if (strobeMode) return (({1'b0, off} + n) > 3'd4) ? 2'd2 : 2'd1;
    if (isAligned(off, sz)) return 2'd1;
    if (sz != SZ_BYTE && sz != SZ_HALF && off[0]) return 2'd3;
    return 2'd2;
  endfunction

  function automatic piece_t pieceAt(input logic strobeMode, input logic [1:0] off,
                                     input logic [1:0] sz, input logic [1:0] k);
    piece_t p;
    logic [2:0] n;
    logic [2:0] head;
    n    = sizeBytes(sz);
    head = 3'd4 - {1'b0, off};
    p    = '{start: 2'd0, len: n};
    if (strobeMode) begin
      if (k == 2'd0) p.len = (n <= head) ? n : head;
      else begin
        p.start = head[1:0];
        p.len   = n - head;
      end
    end else if (!isAligned(off, sz)) begin
      if (sz == SZ_HALF) p = '{start: k, len: 3'd1};
      else if (off == 2'd2) p = '{start: {k[0], 1'b0}, len: 3'd2};
      else begin
        case (k)
          2'd0:    p = '{start: 2'd0, len: 3'd1};
          2'd1:    p = '{start: 2'd1, len: 3'd2};
          default: p = '{start: 2'd3, len: 3'd1};
        endcase
      end
    end
    return p;
  endfunction

  function automatic logic [3:0] laneMask(input logic [1:0] lane, input logic [2:0] len);
    logic [3:0] m;
    case (len)
      3'd1:    m = 4'b0001;
      3'd2:    m = 4'b0011;
      3'd3:    m = 4'b0111;
      default: m = 4'b1111;
    endcase
    return m << lane;
  endfunction

endpackage

// File: rtl/uas_datapath.sv
module uas_datapath
  import uas_pkg::*;
#(
  parameter bit STROBE_MODE = 1'b1,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       memRdata,
  input  logic              memErr,
  output logic [1:0]        numPieces,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  output logic [31:0]       rspRdata,
  output logic              rspErr
);

  logic [ADDR_W-1:0] accAddr;
  logic [1:0]        accSize;
  logic              accWrite;
  logic [31:0]       accWdata;
  logic [31:0]       laneBuf;
  logic              errAcc;

  logic [1:0]        off;
  logic [4:0]        shAmt;
  piece_t            issuePiece, rspPiece;
  logic [ADDR_W-1:0] issueAddr;
  logic [1:0]        rspLane;
  logic [3:0]        rspBe;
  logic [63:0]       wrRot, rdRot;
  logic [31:0]       rdAligned;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accAddr  <= '0;
      accSize  <= SZ_BYTE;
      accWrite <= 1'b0;
      accWdata <= '0;
      laneBuf  <= '0;
      errAcc   <= 1'b0;
    end else if (strb.accept) begin
      accAddr  <= reqAddr;
      accSize  <= reqSize;
      accWrite <= reqWrite;
      accWdata <= reqWdata;
      laneBuf  <= '0;
      errAcc   <= 1'b0;
    end else if (strb.rspBeat) begin
      for (int l = 0; l < 4; l++)
        if (rspBe[l]) laneBuf[8*l +: 8] <= memRdata[8*l +: 8];
      errAcc <= errAcc | memErr;
    end
  end

  assign off        = accAddr[1:0];
  assign shAmt      = {off, 3'b000};
  assign numPieces  = pieceCount(STROBE_MODE, off, accSize);
  assign issuePiece = pieceAt(STROBE_MODE, off, accSize, strb.pieceIdx);
  assign rspPiece   = pieceAt(STROBE_MODE, off, accSize, strb.rspIdx);
  assign issueAddr  = accAddr + ADDR_W'(issuePiece.start);
  assign rspLane    = off + rspPiece.start;
  assign rspBe      = laneMask(rspLane, rspPiece.len);
  assign memBe      = laneMask(issueAddr[1:0], issuePiece.len);
  assign memWe      = accWrite;

  // the access occupies distinct lanes, so one rotation serves every piece
  assign wrRot    = {accWdata, accWdata} << shAmt;
  assign memWdata = wrRot[63:32];

  generate
    if (STROBE_MODE) begin : g_strobe
      assign memAddr = {issueAddr[ADDR_W-1:2], 2'b00};
      assign memSize = SZ_WORD;
    end else begin : g_decomp
      assign memAddr = issueAddr;
      assign memSize = (issuePiece.len == 3'd1) ? SZ_BYTE :
                       (issuePiece.len == 3'd2) ? SZ_HALF : SZ_WORD;
    end
  endgenerate

  assign rdRot     = {laneBuf, laneBuf} >> shAmt;
  assign rdAligned = rdRot[31:0];
  always_comb begin
    case (accSize)
      SZ_BYTE: rspRdata = {24'd0, rdAligned[7:0]};
      SZ_HALF: rspRdata = {16'd0, rdAligned[15:0]};
      default: rspRdata = rdAligned;
    endcase
  end
  assign rspErr = errAcc;

  // R4: decomposed transfers are naturally aligned
  assert_natural_align_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issuing && !STROBE_MODE) |->
      ((memSize == SZ_BYTE) || (memSize == SZ_HALF && !memAddr[0]) ||
       (memSize == SZ_WORD && memAddr[1:0] == 2'b00)));

  // R2/R3: strobe-mode transfers are word addressed with at least one lane
  assert_word_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issuing && STROBE_MODE) |-> (memAddr[1:0] == 2'b00 && $countones(memBe) >= 1));

  // R6: successive pieces of one access move upward in address
  assert_ascending_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issuing && strb.pieceIdx != 2'd0 && $past(strb.issuing)) |->
      (memAddr >= $past(memAddr)));

endmodule

// File: rtl/uas_ctrl.sv
module uas_ctrl
  import uas_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic [1:0] numPieces,
  input  logic      memGnt,
  input  logic      memRvalid,
  output logic      reqReady,
  output logic      memReq,
  output logic      rspValid,
  output ctrlStrb_t strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DRAIN} state_t;

  state_t     state;
  logic [1:0] issueCnt;
  logic [1:0] rspCnt;
  logic [1:0] lastIdx;
  logic       beat;

  assign lastIdx  = numPieces - 2'd1;
  assign reqReady = (state == ST_IDLE);
  assign memReq   = (state == ST_ISSUE);
  assign beat     = memRvalid && (state != ST_IDLE);

  assign strb.accept   = reqValid && reqReady;
  assign strb.issuing  = memReq;
  assign strb.pieceIdx = issueCnt;
  assign strb.rspBeat  = beat;
  assign strb.rspIdx   = rspCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      issueCnt <= 2'd0;
      rspCnt   <= 2'd0;
      rspValid <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      if (state == ST_IDLE) begin
        if (reqValid) begin
          state    <= ST_ISSUE;
          issueCnt <= 2'd0;
          rspCnt   <= 2'd0;
        end
      end else begin
        if (state == ST_ISSUE && memGnt) begin
          if (issueCnt == lastIdx) state <= ST_DRAIN;
          else issueCnt <= issueCnt + 2'd1;
        end
        if (beat) begin
          if (rspCnt == lastIdx) begin
            rspValid <= 1'b1;
            state    <= ST_IDLE;
          end else rspCnt <= rspCnt + 2'd1;
        end
      end
    end
  end

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && $stable(issueCnt)));

  assert_piece_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (issueCnt < numPieces));

  assert_single_rsp_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
  import uas_pkg::*;
#(
  parameter bit STROBE_MODE = 1'b1,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              rspErr,
  output logic              memReq,
  input  logic              memGnt,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic              memRvalid,
  input  logic [31:0]       memRdata,
  input  logic              memErr
);

  ctrlStrb_t  strb;
  logic [1:0] numPieces;

  uas_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .numPieces(numPieces),
    .memGnt   (memGnt),
    .memRvalid(memRvalid),
    .reqReady (reqReady),
    .memReq   (memReq),
    .rspValid (rspValid),
    .strb     (strb)
  );

  uas_datapath #(.STROBE_MODE(STROBE_MODE), .ADDR_W(ADDR_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .memRdata (memRdata),
    .memErr   (memErr),
    .numPieces(numPieces),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memSize  (memSize),
    .memBe    (memBe),
    .memWdata (memWdata),
    .rspRdata (rspRdata),
    .rspErr   (rspErr)
  );

endmodule

// File: tb/test_misalign_splitter.sv
module test_uas_mem (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stallEn,
  input  logic        logClr,
  input  logic [3:0]  errWord,
  input  logic        memReq,
  input  logic        memWe,
  input  logic [31:0] memAddr,
  input  logic [1:0]  memSize,
  input  logic [3:0]  memBe,
  input  logic [31:0] memWdata,
  output logic        memGnt,
  output logic        memRvalid,
  output logic [31:0] memRdata,
  output logic        memErr
);
  logic [31:0] words   [16];
  logic [31:0] logAddr [4];
  logic [3:0]  logBe   [4];
  logic [1:0]  logSize [4];
  int          logCnt;
  logic        stallPh;

  assign memGnt = memReq && !(stallEn && stallPh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++)
        for (int l = 0; l < 4; l++)
          words[i][8*l +: 8] <= 8'(4*i + l) ^ 8'h5A;
      for (int i = 0; i < 4; i++) begin
        logAddr[i] <= '0; logBe[i] <= '0; logSize[i] <= '0;
      end
      logCnt <= 0; stallPh <= 1'b0;
      memRvalid <= 1'b0; memRdata <= '0; memErr <= 1'b0;
    end else begin
      stallPh   <= ~stallPh;
      memRvalid <= 1'b0;
      if (logClr) logCnt <= 0;
      if (memReq && memGnt) begin
        if (logCnt < 4) begin
          logAddr[logCnt] <= memAddr; logBe[logCnt] <= memBe; logSize[logCnt] <= memSize;
        end
        logCnt    <= logCnt + 1;
        memRvalid <= 1'b1;
        memErr    <= (memAddr[5:2] == errWord);
        memRdata  <= words[memAddr[5:2]];
        if (memWe)
          for (int l = 0; l < 4; l++)
            if (memBe[l]) words[memAddr[5:2]][8*l +: 8] <= memWdata[8*l +: 8];
      end
    end
  end
endmodule

module test_misalign_splitter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [1:0]  reqSize = '0;
  logic        stallEn = 1'b0, logClr = 1'b0;
  logic [3:0]  errWord = 4'd15;

  logic        rdyS, rspVS, rspES, mReqS, mGntS, mWeS, mRvS, mErrS;
  logic [31:0] rspDS, mAddrS, mWdS, mRdS;
  logic [1:0]  mSzS;
  logic [3:0]  mBeS;
  logic        rdyD, rspVD, rspED, mReqD, mGntD, mWeD, mRvD, mErrD;
  logic [31:0] rspDD, mAddrD, mWdD, mRdD;
  logic [1:0]  mSzD;
  logic [3:0]  mBeD;

  misalign_splitter #(.STROBE_MODE(1'b1)) i_misalign_splitter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(rdyS), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata), .rspValid(rspVS),
    .rspRdata(rspDS), .rspErr(rspES), .memReq(mReqS), .memGnt(mGntS), .memWe(mWeS),
    .memAddr(mAddrS), .memSize(mSzS), .memBe(mBeS), .memWdata(mWdS),
    .memRvalid(mRvS), .memRdata(mRdS), .memErr(mErrS));

  misalign_splitter #(.STROBE_MODE(1'b0)) i_misalign_splitter_nostrobe (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(rdyD), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata), .rspValid(rspVD),
    .rspRdata(rspDD), .rspErr(rspED), .memReq(mReqD), .memGnt(mGntD), .memWe(mWeD),
    .memAddr(mAddrD), .memSize(mSzD), .memBe(mBeD), .memWdata(mWdD),
    .memRvalid(mRvD), .memRdata(mRdD), .memErr(mErrD));

  test_uas_mem i_memS (.clk(clk), .rstN(rstN), .stallEn(stallEn), .logClr(logClr),
    .errWord(errWord), .memReq(mReqS), .memWe(mWeS), .memAddr(mAddrS), .memSize(mSzS),
    .memBe(mBeS), .memWdata(mWdS), .memGnt(mGntS), .memRvalid(mRvS), .memRdata(mRdS),
    .memErr(mErrS));
  test_uas_mem i_memD (.clk(clk), .rstN(rstN), .stallEn(stallEn), .logClr(logClr),
    .errWord(errWord), .memReq(mReqD), .memWe(mWeD), .memAddr(mAddrD), .memSize(mSzD),
    .memBe(mBeD), .memWdata(mWdD), .memGnt(mGntD), .memRvalid(mRvD), .memRdata(mRdD),
    .memErr(mErrD));

  int checks = 0, failures = 0;
  logic [31:0] gotDS, gotDD;
  logic        gotES, gotED;
  int          pulsesS, pulsesD;

  // {size, offset, strobe-mode count, decomposition count, first strobes, second strobes}
  localparam logic [15:0] VEC [12] = '{
    {2'd0, 2'd0, 2'd1, 2'd1, 4'b0001, 4'b0000},
    {2'd0, 2'd1, 2'd1, 2'd1, 4'b0010, 4'b0000},
    {2'd0, 2'd2, 2'd1, 2'd1, 4'b0100, 4'b0000},
    {2'd0, 2'd3, 2'd1, 2'd1, 4'b1000, 4'b0000},
    {2'd1, 2'd0, 2'd1, 2'd1, 4'b0011, 4'b0000},
    {2'd1, 2'd1, 2'd1, 2'd2, 4'b0110, 4'b0000},
    {2'd1, 2'd2, 2'd1, 2'd1, 4'b1100, 4'b0000},
    {2'd1, 2'd3, 2'd2, 2'd2, 4'b1000, 4'b0001},
    {2'd2, 2'd0, 2'd1, 2'd1, 4'b1111, 4'b0000},
    {2'd2, 2'd1, 2'd2, 2'd3, 4'b1110, 4'b0001},
    {2'd2, 2'd2, 2'd2, 2'd2, 4'b1100, 4'b0011},
    {2'd2, 2'd3, 2'd2, 2'd3, 4'b1000, 4'b0111}
  };

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'(a & 32'd63) ^ 8'h5A;
  endfunction

  function automatic logic [31:0] expRead(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] r;
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    r = '0;
    for (int j = 0; j < 4; j++) if (j < n) r[8*j +: 8] = pat(a + 32'(j));
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic runAccess(input logic we, input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd);
    bit doneS, doneD;
    @(negedge clk);
    logClr = 1'b1;
    @(negedge clk);
    logClr = 1'b0;
    reqValid = 1'b1; reqWrite = we; reqAddr = a; reqSize = sz; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    check(!rdyS && !rdyD, "R10 ready low while busy", {30'd0, rdyS, rdyD}, 32'd0);
    doneS = 0; doneD = 0; pulsesS = 0; pulsesD = 0;
    for (int c = 0; c < 60; c++) begin
      if (rspVS) begin pulsesS++; doneS = 1; gotDS = rspDS; gotES = rspES; end
      if (rspVD) begin pulsesD++; doneD = 1; gotDD = rspDD; gotED = rspED; end
      @(negedge clk);
    end
    check(pulsesS == 1 && pulsesD == 1, "R7 single response pulse",
          32'(pulsesS * 16 + pulsesD), 32'h11);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdyS && rdyD && !mReqS && !mReqD && !rspVS && !rspVD, "R10 reset state",
          {26'd0, rdyS, rdyD, mReqS, mReqD, rspVS, rspVD}, 32'h30);
    rstN = 1'b1;
    @(negedge clk);
    check(rdyS && rdyD, "R10 ready after reset", {30'd0, rdyS, rdyD}, 32'd3);

    // table sweep: loads at every size and offset inside word 4
    for (int v = 0; v < 12; v++) begin
      logic [1:0] sz, off, nS, nD;
      logic [3:0] be0, be1;
      logic [31:0] a;
      bit aligned;
      {sz, off, nS, nD, be0, be1} = VEC[v];
      a = 32'h10 + 32'(off);
      aligned = (sz == 2'd0) || (sz == 2'd1 && !off[0]) || (sz == 2'd2 && off == 2'd0);
      runAccess(1'b0, a, sz, 32'd0);
      check(i_memS.logCnt == int'(nS), aligned ? "R1 strobe count" : "R3 strobe count",
            32'(i_memS.logCnt), 32'(nS));
      check(i_memD.logCnt == int'(nD), aligned ? "R1 decomp count" : "R5 decomp count",
            32'(i_memD.logCnt), 32'(nD));
      check(i_memS.logBe[0] == be0 && i_memS.logAddr[0] == 32'h10, "R2 first strobes",
            {i_memS.logAddr[0][27:0], i_memS.logBe[0]}, {28'h1, be0});
      if (nS == 2'd2)
        check(i_memS.logBe[1] == be1 && i_memS.logAddr[1] == 32'h14, "R3 second strobes",
              {i_memS.logAddr[1][27:0], i_memS.logBe[1]}, {28'h1 + 28'd0 + 28'h0, be1} + 32'h40);
      for (int k = 0; k < 3; k++) if (k < i_memD.logCnt) begin
        logic [31:0] pa;
        logic [1:0]  ps;
        pa = i_memD.logAddr[k]; ps = i_memD.logSize[k];
        check(!((ps == 2'd1 && pa[0]) || (ps == 2'd2 && pa[1:0] != 2'd0) || (!aligned && ps == 2'd2)),
              "R4 natural piece", pa, {30'd0, ps});
        if (k > 0)
          check(pa > i_memD.logAddr[k-1], "R6 ascending pieces", pa, i_memD.logAddr[k-1]);
      end
      if (sz == 2'd2 && off[0])
        check(i_memD.logSize[0] == 2'd0 && i_memD.logSize[1] == 2'd1 && i_memD.logSize[2] == 2'd0,
              "R5 byte-half-byte order",
              {26'd0, i_memD.logSize[0], i_memD.logSize[1], i_memD.logSize[2]}, 32'h04);
      check(gotDS == expRead(a, sz), "R7 strobe merged data", gotDS, expRead(a, sz));
      check(gotDD == expRead(a, sz), "R7 decomp merged data", gotDD, expRead(a, sz));
      check(!gotES && !gotED, "R9 no error flag", {31'd0, gotES | gotED}, 32'd0);
    end

    // R8: store straddling a word, read back through the block
    runAccess(1'b1, 32'h23, 2'd2, 32'h11223344);
    runAccess(1'b0, 32'h23, 2'd2, 32'd0);
    check(gotDS == 32'h11223344, "R8 strobe store readback", gotDS, 32'h11223344);
    check(gotDD == 32'h11223344, "R8 decomp store readback", gotDD, 32'h11223344);
    runAccess(1'b0, 32'h24, 2'd2, 32'd0);
    check(gotDS == {pat(32'h27), 24'h112233}, "R8 strobe neighbour lane", gotDS, {pat(32'h27), 24'h112233});
    check(gotDD == {pat(32'h27), 24'h112233}, "R8 decomp neighbour lane", gotDD, {pat(32'h27), 24'h112233});
    runAccess(1'b0, 32'h22, 2'd0, 32'd0);
    check(gotDS == {24'd0, pat(32'h22)} && gotDD == {24'd0, pat(32'h22)},
          "R8 byte below store untouched", gotDS, {24'd0, pat(32'h22)});

    // R9: error on first piece only, second piece must still run
    runAccess(1'b0, 32'h3E, 2'd2, 32'd0);
    check(gotES && gotED, "R9 error aggregated", {30'd0, gotES, gotED}, 32'd3);
    check(i_memS.logCnt == 2 && i_memD.logCnt == 2, "R9 all pieces completed",
          32'(i_memS.logCnt * 16 + i_memD.logCnt), 32'h22);

    // R6: stalling memory, three-piece access
    stallEn = 1'b1;
    runAccess(1'b0, 32'h11, 2'd2, 32'd0);
    stallEn = 1'b0;
    check(gotDS == expRead(32'h11, 2'd2) && gotDD == expRead(32'h11, 2'd2),
          "R6 stalled access data", gotDD, expRead(32'h11, 2'd2));
    check(i_memD.logCnt == 3 && i_memD.logAddr[0] == 32'h11 && i_memD.logAddr[1] == 32'h12 &&
          i_memD.logAddr[2] == 32'h14, "R6 stalled piece sequence", i_memD.logAddr[2], 32'h14);
    check(rdyS && rdyD, "R10 ready after response", {30'd0, rdyS, rdyD}, 32'd3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule